// File: doc/BRIEF.md
# DRAM Strobe Sequencer

This block sits between a simple host request port and an asynchronous, page-mode DRAM with a 4-bit data path. Each host request is a single read or write. The block splits the flat request address into a row part and a column part. It places them one after the other on a shared address bus and steps the active-low row strobe, column strobe, write enable and output enable through a fixed order. Every phase of that order lasts a minimum number of clock cycles, and each minimum is set by a parameter.

A separate refresh scheduler raises a refresh request. The block answers it with a column-before-row refresh cycle on the same strobes. While the refresh request is high, host requests are held off. Between any two cycles the block keeps both strobes high for the precharge interval, so the row and column precharge minimums are always met.

Top module: `dseq_ctrl`

## Requirements
- R1: After reset, the row strobe, column strobe, write enable and output enable are all high, the data bus driver is off, `rd_valid` is low and `req_ready` is high.
- R2: An accepted request drops the row strobe with the row, which is the upper `ADDR_W` bits of `req_addr`, on `dram_addr`. The row strobe stays low for exactly `T_RCD` cycles before the column strobe falls.
- R3: When the column strobe falls, `dram_addr` carries the column, which is the lower `COL_W` bits of `req_addr`, with zeros in all higher bits.
- R4: The row strobe stays low for at least `T_RAS` cycles. It rises in the same cycle as the column strobe, so the cycle closes with both strobes high.
- R5: Before the row strobe falls again, it has been high for at least max(`T_RP`,`T_CP`) cycles. Before any fall of the column strobe, the column strobe has been high for at least `T_CP` cycles.
- R6: A write drives write enable low and turns on the data driver with `req_wdata` at least one cycle before the column strobe falls. Both stay that way while the column strobe is low, so the write happens on the column strobe edge.
- R7: A read keeps write enable high and drops output enable together with the column strobe. The data input is sampled in the `T_CAS`-th cycle with the column strobe low. The sampled value appears on `rd_data` in the next cycle with `rd_valid` high for exactly one cycle.
- R8: A refresh drops the column strobe first and keeps the row strobe high for exactly `T_CSR` cycles. The row strobe then falls while the column strobe stays low. No data moves during a refresh: write enable and output enable stay high and the data driver stays off. `ref_ack` is high for exactly one cycle, the cycle in which the refresh is taken.
- R9: While `ref_req` is high, `req_ready` is low. When both requests are pending in an idle cycle, the refresh starts first.
- R10: Output enable is low only while both strobes are low in a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request taken on this edge when valid is also high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W+COL_W | Flat address: row in the upper bits, column in the lower bits |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One-cycle read result strobe |
| rd_data | output | DATA_W | Read result |
| ref_req | input | 1 | Refresh request from the scheduler (level) |
| ref_ack | output | 1 | Refresh taken this cycle |
| dram_addr | output | ADDR_W | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | DATA_W | Data toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | DATA_W | Data from the DRAM |

## Verification
The bench builds the block with `ADDR_W=12` and `COL_W=10`, so the column zero-fill on the upper two bus bits can be observed. It uses `T_RCD=2`, `T_CAS=2`, `T_RAS=6`, `T_RP=4`, `T_CP=2` and `T_CSR=2`. Because `T_RAS` exceeds `T_RCD+T_CAS`, every access passes through the hold phase that waits out the active minimum. Because `T_RP` exceeds `T_CP`, the precharge length is chosen by the row term, and `T_CSR=2` makes the refresh lead time a multi-cycle count instead of a single cycle. The behavioural DRAM model drives read data only from the `T_CAS`-th column cycle on, so a read that samples early returns wrong data.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_HOLD,
    ST_PRE,
    ST_RCAS,
    ST_RRAS
  } dseq_state_e;

  function automatic int unsigned cyc_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // bits needed to hold values 0..n
  function automatic int unsigned cnt_bits(input int unsigned n);
    int unsigned w;
    w = $clog2(n + 1);
    return (w < 1) ? 1 : w;
  endfunction

endpackage

// File: rtl/dseq_timer.sv
module dseq_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          done
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load)       cnt_q <= load_val;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/dseq_addr_mux.sv
module dseq_addr_mux #(
  parameter int ADDR_W = 11,
  parameter int COL_W  = 11
) (
  input  logic [ADDR_W+COL_W-1:0] flat_addr,
  input  logic                    sel_row,
  input  logic                    sel_col,
  output logic [ADDR_W-1:0]       bus_addr
);

  function automatic logic [ADDR_W-1:0] row_part(input logic [ADDR_W+COL_W-1:0] a);
    return a[ADDR_W+COL_W-1:COL_W];
  endfunction

  function automatic logic [ADDR_W-1:0] col_part(input logic [ADDR_W+COL_W-1:0] a);
    logic [ADDR_W-1:0] c;
    c = '0;
    c[COL_W-1:0] = a[COL_W-1:0];
    return c;
  endfunction

  always_comb begin
    if (sel_row)      bus_addr = row_part(flat_addr);
    else if (sel_col) bus_addr = col_part(flat_addr);
    else              bus_addr = '0;
  end

endmodule

// File: rtl/dseq_ctrl.sv
module dseq_ctrl
  import dseq_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int COL_W  = 11,
  parameter int DATA_W = 4,
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 2,
  parameter int T_RAS  = 5,
  parameter int T_RP   = 3,
  parameter int T_CP   = 2,
  parameter int T_CSR  = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    rd_valid,
  output logic [DATA_W-1:0]       rd_data,
  input  logic                    ref_req,
  output logic                    ref_ack,
  output logic [ADDR_W-1:0]       dram_addr,
  output logic                    dram_ras_n,
  output logic                    dram_cas_n,
  output logic                    dram_we_n,
  output logic                    dram_oe_n,
  output logic [DATA_W-1:0]       dram_dq_out,
  output logic                    dram_dq_oe,
  input  logic [DATA_W-1:0]       dram_dq_in
);

  localparam int HA_W    = ADDR_W + COL_W;
  localparam int PRE_CYC = cyc_max(T_RP, T_CP);
  localparam int MAX_T   = cyc_max(cyc_max(cyc_max(T_RCD, T_CAS), cyc_max(T_RAS, PRE_CYC)), T_CSR);
  localparam int TW      = cnt_bits(MAX_T);

  dseq_state_e state_q, state_d;

  logic              wr_q;
  logic [HA_W-1:0]   addr_q;
  logic [DATA_W-1:0] wdata_q;

  // named internal events
  logic          accept;
  logic          ph_load, ph_done;
  logic [TW-1:0] ph_val;
  logic          tras_load, tras_done;
  logic          sample_now;
  logic          sel_row, sel_col;

  assign req_ready  = (state_q == ST_IDLE) && !ref_req;
  assign ref_ack    = (state_q == ST_IDLE) && ref_req;
  assign accept     = req_valid && req_ready;
  assign sample_now = (state_q == ST_COL) && ph_done && !wr_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (ref_req) state_d = ST_RCAS;
               else if (req_valid) state_d = ST_ROW;
      ST_ROW:  if (ph_done) state_d = ST_COL;
      ST_COL:  if (ph_done) state_d = tras_done ? ST_PRE : ST_HOLD;
      ST_HOLD: if (tras_done) state_d = ST_PRE;
      ST_PRE:  if (ph_done) state_d = ST_IDLE;
      ST_RCAS: if (ph_done) state_d = ST_RRAS;
      ST_RRAS: if (tras_done) state_d = ST_PRE;
      default: state_d = ST_IDLE;
    endcase
  end

  // phase timer reloads on every state change
  always_comb begin
    ph_load = (state_d != state_q);
    unique case (state_d)
      ST_ROW:  ph_val = TW'(T_RCD - 1);
      ST_COL:  ph_val = TW'(T_CAS - 1);
      ST_PRE:  ph_val = TW'(PRE_CYC - 1);
      ST_RCAS: ph_val = TW'(T_CSR - 1);
      default: ph_val = '0;
    endcase
  end

  // active-time timer starts when the row strobe falls
  assign tras_load = ((state_d == ST_ROW)  && (state_q != ST_ROW)) ||
                     ((state_d == ST_RRAS) && (state_q != ST_RRAS));

  dseq_timer #(.TW(TW)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .done(ph_done)
  );

  dseq_timer #(.TW(TW)) u_tras (
    .clk(clk), .rst_n(rst_n), .load(tras_load),
    .load_val(TW'(T_RAS - 1)), .done(tras_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      wr_q     <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      state_q  <= state_d;
      rd_valid <= sample_now;
      if (accept) begin
        wr_q    <= req_write;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (sample_now) rd_data <= dram_dq_in;
    end
  end

  // strobe decode
  always_comb begin
    dram_ras_n = 1'b1;
    dram_cas_n = 1'b1;
    dram_we_n  = 1'b1;
    dram_oe_n  = 1'b1;
    dram_dq_oe = 1'b0;
    sel_row    = 1'b0;
    sel_col    = 1'b0;
    unique case (state_q)
      ST_ROW: begin
        dram_ras_n = 1'b0;
        dram_we_n  = !wr_q;
        dram_dq_oe = wr_q;
        sel_row    = 1'b1;
      end
      ST_COL, ST_HOLD: begin
        dram_ras_n = 1'b0;
        dram_cas_n = 1'b0;
        dram_we_n  = !wr_q;
        dram_oe_n  = wr_q;
        dram_dq_oe = wr_q;
        sel_col    = 1'b1;
      end
      ST_RCAS: dram_cas_n = 1'b0;
      ST_RRAS: begin
        dram_ras_n = 1'b0;
        dram_cas_n = 1'b0;
      end
      default: ;
    endcase
  end

  assign dram_dq_out = wdata_q;

  dseq_addr_mux #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_amux (
    .flat_addr(addr_q), .sel_row(sel_row), .sel_col(sel_col), .bus_addr(dram_addr)
  );

  // R4
  ras_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |-> $past(tras_done) && dram_cas_n);

  // R9
  ref_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> !req_ready);

  // R10
  oe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_oe_n |-> !dram_ras_n && !dram_cas_n && dram_we_n && !dram_dq_oe);

  // R7
  rdv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R8
  ref_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_cas_n && dram_ras_n) |-> dram_we_n && dram_oe_n && !dram_dq_oe);

  // R8
  ref_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_ras_n) && !dram_cas_n) |-> !$past(dram_cas_n));

  // R6
  write_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && !dram_we_n) |-> dram_dq_oe && !$past(dram_we_n));

endmodule

// File: tb/test_dseq_ctrl.sv
module test_dseq_ctrl;

  localparam int ADDR_W = 12;
  localparam int COL_W  = 10;
  localparam int DATA_W = 4;
  localparam int HA_W   = ADDR_W + COL_W;
  localparam int T_RCD  = 2;
  localparam int T_CAS  = 2;
  localparam int T_RAS  = 6;
  localparam int T_RP   = 4;
  localparam int T_CP   = 2;
  localparam int T_CSR  = 2;
  localparam int PRE    = (T_RP > T_CP) ? T_RP : T_CP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0;
  logic [HA_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, rd_valid, ref_ack;
  logic [DATA_W-1:0] rd_data, dram_dq_out;
  logic [DATA_W-1:0] dram_dq_in = '0;
  logic [ADDR_W-1:0] dram_addr;
  logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;

  always #5 clk = ~clk;

  dseq_ctrl #(.ADDR_W(ADDR_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RCD(T_RCD),
              .T_CAS(T_CAS), .T_RAS(T_RAS), .T_RP(T_RP), .T_CP(T_CP), .T_CSR(T_CSR))
  i_dseq_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req), .ref_ack(ref_ack),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  typedef struct { bit wr; logic [HA_W-1:0] addr; logic [DATA_W-1:0] data; } acc_t;
  acc_t acc_q[$];
  logic [DATA_W-1:0] rd_q[$];
  logic [DATA_W-1:0] mem    [logic [HA_W-1:0]];
  logic [DATA_W-1:0] shadow [logic [HA_W-1:0]];

  int checks = 0, errors = 0, refreshes = 0, exp_ref = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] mem_rd(input logic [HA_W-1:0] a);
    return mem.exists(a) ? mem[a] : '0;
  endfunction

  function automatic logic [DATA_W-1:0] sh_rd(input logic [HA_W-1:0] a);
    return shadow.exists(a) ? shadow[a] : '0;
  endfunction

  // behavioural DRAM model and monitor
  int ras_lo = 0, ras_hi = 1000, cas_lo = 0, cas_hi = 1000;
  logic p_ras = 1, p_cas = 1, p_we = 1, p_rdv = 0, p_ack = 0;
  logic [ADDR_W-1:0] row_l = '0;
  logic [HA_W-1:0] rd_addr = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!p_ras && dram_ras_n) begin
        chk(ras_lo >= T_RAS, "R4 row strobe low time", ras_lo, T_RAS);
        chk(dram_cas_n == 1'b1, "R4 column strobe rises with row strobe", dram_cas_n, 1);
      end
      if (p_ras && !dram_ras_n) begin
        chk(ras_hi >= PRE, "R5 row precharge", ras_hi, PRE);
        if (!dram_cas_n) begin
          refreshes++;
          chk(cas_lo == T_CSR, "R8 column lead before row", cas_lo, T_CSR);
          chk(dram_we_n && dram_oe_n && !dram_dq_oe, "R8 no data in refresh",
              {dram_we_n, dram_oe_n, dram_dq_oe}, 3'b110);
        end else begin
          row_l = dram_addr;
        end
      end
      if (p_cas && !dram_cas_n) begin
        chk(cas_hi >= T_CP, "R5 column precharge", cas_hi, T_CP);
        if (!dram_ras_n) begin
          logic [HA_W-1:0] full;
          chk(ras_lo == T_RCD, "R2 row to column delay", ras_lo, T_RCD);
          chk((dram_addr >> COL_W) == 0, "R3 column upper bits zero", dram_addr, dram_addr[COL_W-1:0]);
          full = {row_l, dram_addr[COL_W-1:0]};
          if (acc_q.size() == 0) chk(0, "R2 unexpected access", full, 0);
          else begin
            acc_t it;
            it = acc_q.pop_front();
            chk(full == it.addr, "R3 row and column address", full, it.addr);
            chk(dram_we_n == !it.wr, "R6 access kind", dram_we_n, !it.wr);
            if (!dram_we_n) begin
              chk(!p_we && dram_dq_oe, "R6 write enable and data set up early", {p_we, dram_dq_oe}, 2'b01);
              chk(dram_dq_out == it.data, "R6 write data", dram_dq_out, it.data);
              mem[full] = dram_dq_out;
            end else begin
              chk(!dram_oe_n, "R7 output enable with column strobe", dram_oe_n, 0);
              rd_addr = full;
            end
          end
        end
      end
      if (!dram_oe_n && !(!dram_ras_n && !dram_cas_n && dram_we_n))
        chk(0, "R10 output enable outside read", {dram_ras_n, dram_cas_n, dram_we_n}, 3'b001);
      if (dram_dq_oe && dram_ras_n)
        chk(0, "R8 data driven without row strobe", dram_dq_oe, 0);
      if (!dram_ras_n) begin ras_lo++; ras_hi = 0; end else begin ras_hi++; ras_lo = 0; end
      if (!dram_cas_n) begin cas_lo++; cas_hi = 0; end else begin cas_hi++; cas_lo = 0; end
      if (!dram_ras_n && !dram_cas_n && dram_we_n && !dram_oe_n)
        dram_dq_in <= (cas_lo >= T_CAS) ? mem_rd(rd_addr) : ~mem_rd(rd_addr);
      else
        dram_dq_in <= '0;
      if (rd_valid) begin
        chk(!p_rdv, "R7 single valid pulse", p_rdv, 0);
        if (rd_q.size() == 0) chk(0, "R7 unexpected read result", rd_data, 0);
        else begin
          logic [DATA_W-1:0] e;
          e = rd_q.pop_front();
          chk(rd_data == e, "R7 read data", rd_data, e);
        end
      end
      if (ref_ack) chk(!p_ack, "R8 acknowledge pulse", p_ack, 0);
      p_ras = dram_ras_n; p_cas = dram_cas_n; p_we = dram_we_n;
      p_rdv = rd_valid; p_ack = ref_ack;
    end
  end

  task automatic host_op(input bit wr, input logic [HA_W-1:0] a, input logic [DATA_W-1:0] d);
    acc_t it;
    it.wr = wr; it.addr = a; it.data = d;
    acc_q.push_back(it);
    if (wr) shadow[a] = d;
    else rd_q.push_back(sh_rd(a));
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic refresh_op();
    exp_ref++;
    ref_req = 1'b1;
    while (!ref_ack) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    ref_req = 1'b0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes high in reset",
        {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 4'hf);
    chk(!dram_dq_oe && !rd_valid, "R1 driver off and no result", {dram_dq_oe, rd_valid}, 0);
    chk(req_ready, "R1 ready after reset", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && dram_ras_n, "R1 idle after reset", {req_ready, dram_ras_n}, 2'b11);

    // writes and reads over address corners
    host_op(1, 22'h000000, 4'h5);
    host_op(1, 22'h3FFFFF, 4'hA);
    host_op(1, {12'hABC, 10'h3FF}, 4'h3);
    host_op(1, {12'hFFF, 10'h000}, 4'hC);
    host_op(0, 22'h000000, 4'h0);
    host_op(0, 22'h3FFFFF, 4'h0);
    host_op(0, {12'hABC, 10'h3FF}, 4'h0);
    host_op(0, {12'hFFF, 10'h000}, 4'h0);

    // refresh alone
    refresh_op();
    refresh_op();

    // overwrite then read back
    host_op(1, {12'h123, 10'h155}, 4'h9);
    host_op(1, {12'h123, 10'h155}, 4'h6);
    host_op(0, {12'h123, 10'h155}, 4'h0);

    // R9 both pending in the same idle cycle
    while (!req_ready) @(negedge clk);
    ref_req = 1'b1;
    req_valid = 1'b1; req_write = 1'b0; req_addr = {12'hABC, 10'h3FF};
    #1;
    chk(!req_ready && ref_ack, "R9 refresh wins, host held off", {req_ready, ref_ack}, 2'b01);
    ref_req = 1'b0; req_valid = 1'b0;
    fork
      refresh_op();
      begin
        @(negedge clk);
        host_op(0, {12'hABC, 10'h3FF}, 4'h0);
      end
    join
    chk(refreshes == exp_ref, "R9 refresh ran before held access", refreshes, exp_ref);

    host_op(0, 22'h3FFFFF, 4'h0);
    host_op(1, {12'h001, 10'h002}, 4'hF);
    refresh_op();
    host_op(0, {12'h001, 10'h002}, 4'h0);

    repeat (30) @(negedge clk);
    chk(acc_q.size() == 0, "R2 all accesses seen", acc_q.size(), 0);
    chk(rd_q.size() == 0, "R7 all reads returned", rd_q.size(), 0);
    chk(refreshes == exp_ref, "R8 refresh count", refreshes, exp_ref);
    chk(dram_ras_n && dram_cas_n && dram_oe_n, "R10 idle strobes high",
        {dram_ras_n, dram_cas_n, dram_oe_n}, 3'b111);
    finish_run();
  end

endmodule